// File: doc/BRIEF.md
# Iterative Factorial Register Unit

This block is a small compute engine behind a register port. Software writes an operand into the value register. The unit then works out the factorial of that operand, one multiply per clock cycle, in 32-bit arithmetic that wraps on overflow. When it finishes, it writes the result back into the same value register. A status register shows whether a computation is still running. It also holds a software-set enable that decides whether completion raises an interrupt.

Two further registers let software check the register path. One reads a fixed identity word. The other stores the bitwise complement of whatever was last written to it.

The register port carries requests on a valid/ready handshake. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Each accepted read produces exactly one response on `rsp_valid`/`rsp_rdata`, one cycle later. Accepted writes produce no response. A response stays on the port until the cycle in which `rsp_ready` is high. The block is `req_ready = !rsp_valid || rsp_ready`, so requests are back-pressured only while an unconsumed response is pending. The interrupt line `done_irq` is a plain level output.

Top module: `fact_engine_top`

## Requirements
- R1: After reset `rsp_valid` and `done_irq` are low. The value register (0x08), the status register (0x20), the interrupt status register (0x24) and the test register (0x04) all read 0.
- R2: A 32-bit read of offset 0x00 returns 0x010000ED.
- R3: A 32-bit write to offset 0x04 stores the bitwise inverse of the written data, and later reads of 0x04 return that inverse.
- R4: A 32-bit write to 0x08 while idle starts a computation. Later, 0x08 reads n·(n−1)·…·1 modulo 2^32, and an operand of 0 gives 1. The unit is busy for n+1 cycles.
- R5: A write to 0x08 while the unit is busy is ignored and does not change the result of the running computation.
- R6: While busy, a read of 0x08 returns the operand that started the computation.
- R7: Status bit 0 is the busy flag and cannot be written. Status bit 7 is the interrupt enable: it is writable and reads back what was written. All other status bits read 0.
- R8: On completion, bit 0 of the interrupt status (0x24) is set and `done_irq` goes high, but only if status bit 7 is 1. If bit 7 is 0, neither happens.
- R9: Writing a word with bit 0 set to offset 0x64 clears interrupt status bit 0 and drops `done_irq`. `done_irq` equals interrupt status bit 0.
- R10: `req_size` encodes log2 of the access size in bytes, so 2 means 32 bits. Any access with another size is ignored on write and reads back 0xFFFFFFFF. A 32-bit read of an unmapped offset also reads 0xFFFFFFFF.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_rdata` stays unchanged and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Byte offset |
| req_size | input | 2 | log2 of access size in bytes (2 = 32 bits) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumed |
| rsp_rdata | output | 32 | Read data |
| done_irq | output | 1 | Completion interrupt request (level) |

## Verification
The hardest situation to reach from the ports is the busy window. It lasts only n+1 cycles, and within it the bench needs to see a read returning the operand and a second operand write being dropped. The stimulus reaches it by starting a large operand and then issuing the read and the ignored write back to back. Only after both does it poll status, and the final result must match the first operand alone. The same idea is applied with random operands and random interrupt enables. A stalled response is forced by holding `rsp_ready` low across several cycles.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int unsigned WORD_W = 32;

  // access size encoding: log2 of bytes
  localparam logic [1:0] SIZE_WORD = 2'd2;

  // register offsets
  localparam int unsigned OFS_ID      = 'h00;
  localparam int unsigned OFS_TEST    = 'h04;
  localparam int unsigned OFS_VALUE   = 'h08;
  localparam int unsigned OFS_STATUS  = 'h20;
  localparam int unsigned OFS_IRQ     = 'h24;
  localparam int unsigned OFS_IRQ_CLR = 'h64;

  localparam logic [WORD_W-1:0] ID_WORD = 32'h0100_00ED;

  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_IEN_BIT  = 7;
  localparam int unsigned IRQ_DONE_BIT  = 0;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_TEST,
    TGT_VALUE,
    TGT_STATUS,
    TGT_IRQ,
    TGT_IRQ_CLR
  } fe_target_e;
endpackage

// File: rtl/fe_decode.sv
module fe_decode
  import fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output fe_target_e        target,
  output logic              size_ok
);
  // every register of this block lies below 0x80, where only word access is legal
  assign size_ok = (size == SIZE_WORD);

  always_comb begin
    unique case (addr)
      ADDR_W'(OFS_ID):      target = TGT_ID;
      ADDR_W'(OFS_TEST):    target = TGT_TEST;
      ADDR_W'(OFS_VALUE):   target = TGT_VALUE;
      ADDR_W'(OFS_STATUS):  target = TGT_STATUS;
      ADDR_W'(OFS_IRQ):     target = TGT_IRQ;
      ADDR_W'(OFS_IRQ_CLR): target = TGT_IRQ_CLR;
      default:              target = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/fe_fact_core.sv
module fe_fact_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] operand,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  logic [DW-1:0] acc_q;
  logic [DW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        acc_q <= DW'(acc_q * cnt_q);
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      acc_q  <= DW'(1);
      cnt_q  <= operand;
    end
  end

  assign busy   = busy_q;
  // final cycle: the product is complete and busy clears at this edge
  assign done   = busy_q && (cnt_q == '0);
  assign result = acc_q;
endmodule

// File: rtl/fe_irq_ctl.sv
module fe_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  output logic pending,
  output logic irq
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (raise)  pend_q <= 1'b1;
    else if (clear)  pend_q <= 1'b0;
  end

  assign pending = pend_q;
  assign irq     = pend_q;
endmodule

// File: rtl/fact_engine_top.sv
module fact_engine_top
  import fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              done_irq
);
  localparam int unsigned DW = WORD_W;

  fe_target_e    target;
  logic          size_ok;
  logic          accept;
  logic          wr_ok;
  logic          core_busy;
  logic          core_done;
  logic          core_start;
  logic [DW-1:0] core_result;
  logic          irq_pend;
  logic [DW-1:0] value_q;
  logic [DW-1:0] test_q;
  logic          ien_q;
  logic [DW-1:0] rd_mux;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  fe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (req_addr),
    .size    (req_size),
    .target  (target),
    .size_ok (size_ok)
  );

  assign req_ready  = !rsp_valid_q || rsp_ready;
  assign accept     = req_valid && req_ready;
  assign wr_ok      = accept && req_write && size_ok;
  assign core_start = wr_ok && (target == TGT_VALUE) && !core_busy;

  fe_fact_core #(.DW(DW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (core_start),
    .operand (req_wdata),
    .busy    (core_busy),
    .done    (core_done),
    .result  (core_result)
  );

  fe_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise   (core_done && ien_q),
    .clear   (wr_ok && (target == TGT_IRQ_CLR) && req_wdata[IRQ_DONE_BIT]),
    .pending (irq_pend),
    .irq     (done_irq)
  );

  // shared operand / result register
  always_ff @(posedge clk) begin
    if (!rst_n)          value_q <= '0;
    else if (core_done)  value_q <= core_result;
    else if (core_start) value_q <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_q <= '0;
      ien_q  <= 1'b0;
    end else if (wr_ok) begin
      if (target == TGT_TEST)   test_q <= ~req_wdata;
      if (target == TGT_STATUS) ien_q  <= req_wdata[STAT_IEN_BIT];
    end
  end

  always_comb begin
    rd_mux = '1;
    if (size_ok) begin
      unique case (target)
        TGT_ID:     rd_mux = ID_WORD;
        TGT_TEST:   rd_mux = test_q;
        TGT_VALUE:  rd_mux = value_q;
        TGT_STATUS: begin
          rd_mux = '0;
          rd_mux[STAT_BUSY_BIT] = core_busy;
          rd_mux[STAT_IEN_BIT]  = ien_q;
        end
        TGT_IRQ: begin
          rd_mux = '0;
          rd_mux[IRQ_DONE_BIT] = irq_pend;
        end
        default:    rd_mux = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              done_irq,
  input logic              core_busy,
  input logic              core_done,
  input logic              ien_q,
  input logic [31:0]       value_q
);
  logic rd_acc;
  assign rd_acc = req_valid && req_ready && !req_write;

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_id_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_addr == '0 && req_size == 2'd2 |=> rsp_rdata == 32'h0100_00ED);

  assert_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_size != 2'd2 |=> rsp_rdata == 32'hFFFF_FFFF);

  assert_value_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy && !core_done |=> $stable(value_q));

  assert_irq_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && ien_q |=> done_irq);
endmodule

bind fact_engine_top fe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .done_irq  (done_irq),
  .core_busy (core_busy),
  .core_done (core_done),
  .ien_q     (ien_q),
  .value_q   (value_q)
);

// File: tb/sim_fact_engine_top.sv
`timescale 1ns/1ps
module sim_fact_engine_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        done_irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fact_engine_top #(.ADDR_W(20)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .done_irq(done_irq)
  );

  function automatic logic [31:0] fact_ref(input logic [31:0] n);
    logic [31:0] r = 32'd1;
    for (int i = 1; i <= int'(n); i++) r = r * 32'(i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_0000;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h1;
    for (int k = 0; k < 5000 && st[0]; k++) rd(20'h20, st);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] st;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 done_irq", {31'b0, done_irq}, 32'd0);
    rd(20'h08, d); chk("R1 value", d, 32'd0);
    rd(20'h20, d); chk("R1 status", d, 32'd0);
    rd(20'h24, d); chk("R1 irq status", d, 32'd0);
    rd(20'h04, d); chk("R1 test", d, 32'd0);

    // R2 identity
    rd(20'h00, d); chk("R2 id", d, 32'h0100_00ED);

    // R3 inverter
    wr(20'h04, 32'h1234_5678); rd(20'h04, d); chk("R3 inverse", d, 32'hEDCB_A987);

    // R10 size and unmapped
    wr(20'h04, 32'h0, 2'd1); rd(20'h04, d); chk("R10 bad-size write ignored", d, 32'hEDCB_A987);
    wr(20'h04, 32'h0, 2'd3); rd(20'h04, d); chk("R10 8-byte write ignored", d, 32'hEDCB_A987);
    rd(20'h00, d, 2'd0); chk("R10 bad-size read", d, 32'hFFFF_FFFF);
    rd(20'h10, d); chk("R10 unmapped read", d, 32'hFFFF_FFFF);
    rd(20'h80, d); chk("R10 unmapped high read", d, 32'hFFFF_FFFF);

    // R7 status bits
    wr(20'h20, 32'h0000_0001); rd(20'h20, d); chk("R7 busy not writable", d, 32'd0);
    wr(20'h20, 32'hFFFF_FFFF); rd(20'h20, d); chk("R7 enable set, others zero", d, 32'h80);
    wr(20'h20, 32'h0);         rd(20'h20, d); chk("R7 enable cleared", d, 32'd0);

    // R4 operand 0
    wr(20'h08, 32'd0); wait_idle(st); rd(20'h08, d); chk("R4 zero operand", d, 32'd1);

    // R6 / R5 busy window, R4 wrap
    wr(20'h08, 32'd40);
    rd(20'h20, d); chk("R4 busy during run", d & 32'h1, 32'h1);
    rd(20'h08, d); chk("R6 operand while busy", d, 32'd40);
    wr(20'h08, 32'd3);
    rd(20'h08, d); chk("R5 write while busy ignored", d, 32'd40);
    wait_idle(st);
    rd(20'h08, d); chk("R5 R4 result of first operand", d, fact_ref(32'd40));

    // R8 / R9 interrupt path
    wr(20'h20, 32'h80);
    wr(20'h08, 32'd5); wait_idle(st);
    @(negedge clk);
    chk("R8 irq raised", {31'b0, done_irq}, 32'd1);
    rd(20'h24, d); chk("R8 irq status", d, 32'd1);
    rd(20'h08, d); chk("R4 five", d, 32'd120);
    wr(20'h64, 32'h0); @(negedge clk);
    chk("R9 clear needs bit0", {31'b0, done_irq}, 32'd1);
    wr(20'h64, 32'h1); @(negedge clk);
    chk("R9 irq cleared", {31'b0, done_irq}, 32'd0);
    rd(20'h24, d); chk("R9 irq status cleared", d, 32'd0);
    wr(20'h20, 32'h0);
    wr(20'h08, 32'd4); wait_idle(st); @(negedge clk);
    chk("R8 no irq when disabled", {31'b0, done_irq}, 32'd0);

    // R11 back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 valid held", {31'b0, rsp_valid}, 32'd1);
    chk("R11 data held", rsp_rdata, 32'h0100_00ED);
    chk("R11 req_ready low", {31'b0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", {31'b0, rsp_valid}, 32'd0);

    // random operands and enables
    for (int it = 0; it < 24; it++) begin
      logic [31:0] op;
      logic        en;
      op = $urandom % 48;
      en = 1'($urandom);
      wr(20'h20, {24'b0, en, 7'b0});
      wr(20'h08, op);
      wr(20'h08, op + 32'd1);
      wait_idle(st);
      @(negedge clk);
      rd(20'h08, d); chk("R4 R5 random result", d, fact_ref(op));
      chk("R8 random irq", {31'b0, done_irq}, {31'b0, en});
      wr(20'h64, 32'h1);
    end

    finish_run();
  end
endmodule